// File: doc/BRIEF.md
# Authentication Result Indicator Driver

This block turns the verdict of a challenge-and-response authentication into two indicator drive enables, one for a pass lamp and one for a fail lamp. Each output is active low: a 0 asks the external open-drain stage to pull the pin low, a 1 leaves the pin released (high-impedance). The analog drivers themselves sit outside the block.

A verdict arrives as a one-cycle done strobe with a pass/fail code. It is registered, so the outputs change on the clock edge that samples the strobe and then hold. While an authentication attempt is running, the display is frozen at its last value. A failure can be shown either as a steady low on the fail output or as a 50% duty blink whose half period is a parameter counted in clock cycles; the choice is taken from a mode input when the verdict is accepted. A clear request, raised when the trigger goes inactive or when a bus reset finds no token, releases both outputs.

Top module: `result_lamp_ctrl`

## Requirements
- R1: After reset, `pass_drv_n` and `fail_drv_n` are both 1 (released).
- R2: A `res_valid` pulse with `res_pass`=1, while `busy`=0 and `clr_req`=0, gives `pass_drv_n`=0 and `fail_drv_n`=1 from the clock edge that samples it, and that display holds until the next accepted event.
- R3: A `res_valid` pulse with `res_pass`=0 and `blink_mode`=0, while `busy`=0 and `clr_req`=0, gives `fail_drv_n`=0 steadily and `pass_drv_n`=1.
- R4: A `res_valid` pulse with `res_pass`=0 and `blink_mode`=1 starts a blink: `fail_drv_n` is 0 for `HALF_CYC` cycles starting with the cycle after the accepting edge, then 1 for `HALF_CYC` cycles, repeating; `pass_drv_n` stays 1.
- R5: Each newly accepted blinking fail verdict restarts the blink in its low phase with a full `HALF_CYC` low interval, whatever the phase was before.
- R6: While `busy`=1, `res_valid` is ignored and the displayed verdict is kept (a running blink continues).
- R7: `clr_req`=1 releases both outputs from the next clock edge, taking priority over `res_valid` and `busy`.
- R8: `blink_mode` only matters at the edge that accepts a fail verdict; later changes do not alter the display.
- R9: `pass_drv_n` and `fail_drv_n` are never 0 at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| res_valid | input | 1 | One-cycle done strobe carrying a verdict |
| res_pass | input | 1 | Verdict code: 1 pass, 0 fail |
| busy | input | 1 | Authentication attempt in progress |
| clr_req | input | 1 | Clear display (trigger inactive or token absent) |
| blink_mode | input | 1 | 1 shows failure as a blink, 0 as a steady low |
| pass_drv_n | output | 1 | Pass pin drive enable, 0 pulls low |
| fail_drv_n | output | 1 | Fail pin drive enable, 0 pulls low |

## Verification
The verdict path is driven with a pass strobe, a steady fail and a blinking fail, which separates the three displays and confirms the pass lamp never lights with a fail. The blink is traced cycle by cycle over several periods, then a second fail verdict is injected mid high phase to tell a restarted phase from a free-running one. Strobes during `busy`, a mode flip after acceptance, and a clear coinciding with a strobe show which inputs are ignored and which one wins.

// File: rtl/result_lamp_pkg.sv
package result_lamp_pkg;

  typedef enum logic [1:0] {
    LAMP_OFF   = 2'd0,
    LAMP_PASS  = 2'd1,
    LAMP_FAIL  = 2'd2,
    LAMP_BLINK = 2'd3
  } lamp_e;

endpackage

// File: rtl/lamp_blink_div.sv
module lamp_blink_div #(
  parameter int HALF_CYC = 250000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic restart,
  output logic phase_on
);
  localparam int CW = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;
  localparam logic [CW-1:0] LAST = CW'(HALF_CYC - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          ph_q, ph_d;
  logic          cnt_en;

  assign cnt_en = restart | run;

  always_comb begin
    cnt_d = cnt_q;
    ph_d  = ph_q;
    if (restart) begin
      cnt_d = '0;
      ph_d  = 1'b1;
    end else if (run) begin
      if (cnt_q == LAST) begin
        cnt_d = '0;
        ph_d  = ~ph_q;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      ph_q  <= 1'b0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
      ph_q  <= ph_d;
    end
  end

  assign phase_on = ph_q;
endmodule

// File: rtl/lamp_verdict_reg.sv
module lamp_verdict_reg
  import result_lamp_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  res_valid,
  input  logic  res_pass,
  input  logic  busy,
  input  logic  clr_req,
  input  logic  blink_mode,
  output lamp_e lamp_q,
  output logic  blink_restart
);
  lamp_e lamp_d;
  logic  accept;
  logic  upd_en;

  assign accept = res_valid & ~busy & ~clr_req;
  assign upd_en = accept | clr_req;

  always_comb begin
    lamp_d = lamp_q;
    if (clr_req)
      lamp_d = LAMP_OFF;
    else if (accept) begin
      if (res_pass)        lamp_d = LAMP_PASS;
      else if (blink_mode) lamp_d = LAMP_BLINK;
      else                 lamp_d = LAMP_FAIL;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      lamp_q <= LAMP_OFF;
    else if (upd_en)
      lamp_q <= lamp_d;
  end

  assign blink_restart = accept & ~res_pass & blink_mode;
endmodule

// File: rtl/result_lamp_ctrl.sv
module result_lamp_ctrl
  import result_lamp_pkg::*;
#(
  parameter int HALF_CYC = 250000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic res_valid,
  input  logic res_pass,
  input  logic busy,
  input  logic clr_req,
  input  logic blink_mode,
  output logic pass_drv_n,
  output logic fail_drv_n
);
  lamp_e lamp_q;
  logic  blink_restart;
  logic  blink_run;
  logic  phase_on;

  lamp_verdict_reg u_verdict (
    .clk           (clk),
    .rst_n         (rst_n),
    .res_valid     (res_valid),
    .res_pass      (res_pass),
    .busy          (busy),
    .clr_req       (clr_req),
    .blink_mode    (blink_mode),
    .lamp_q        (lamp_q),
    .blink_restart (blink_restart)
  );

  assign blink_run = (lamp_q == LAMP_BLINK);

  lamp_blink_div #(.HALF_CYC(HALF_CYC)) u_blink (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (blink_run),
    .restart  (blink_restart),
    .phase_on (phase_on)
  );

  always_comb begin
    pass_drv_n = 1'b1;
    fail_drv_n = 1'b1;
    unique case (lamp_q)
      LAMP_PASS:  pass_drv_n = 1'b0;
      LAMP_FAIL:  fail_drv_n = 1'b0;
      LAMP_BLINK: fail_drv_n = ~phase_on;
      default:    ;
    endcase
  end
endmodule

// File: rtl/result_lamp_chk.sv
module result_lamp_chk (
  input logic clk,
  input logic rst_n,
  input logic res_valid,
  input logic res_pass,
  input logic busy,
  input logic clr_req,
  input logic blink_mode,
  input logic pass_drv_n,
  input logic fail_drv_n
);
  // R7
  clear_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_req |=> (pass_drv_n && fail_drv_n));

  // R2
  pass_show_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_pass && !busy && !clr_req) |=> (!pass_drv_n && fail_drv_n));

  // R3
  fail_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_pass && !blink_mode && !busy && !clr_req) |=> (pass_drv_n && !fail_drv_n));

  // R4
  blink_first_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_pass && blink_mode && !busy && !clr_req) |=> (pass_drv_n && !fail_drv_n));

  // R6
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !clr_req) |=> $stable(pass_drv_n));

  // R9
  never_both_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pass_drv_n || fail_drv_n));
endmodule

bind result_lamp_ctrl result_lamp_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .res_valid  (res_valid),
  .res_pass   (res_pass),
  .busy       (busy),
  .clr_req    (clr_req),
  .blink_mode (blink_mode),
  .pass_drv_n (pass_drv_n),
  .fail_drv_n (fail_drv_n)
);

// File: tb/result_lamp_ctrl_tb.sv
module result_lamp_ctrl_tb;
  localparam int CLK_PERIOD = 10;
  localparam int HALF = 4;

  logic clk = 1'b0;
  logic rst_n;
  logic res_valid, res_pass, busy, clr_req, blink_mode;
  logic pass_drv_n, fail_drv_n;
  int   n_tests = 0;
  int   n_fail  = 0;
  bit   done    = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  result_lamp_ctrl #(.HALF_CYC(HALF)) u_dut (
    .clk(clk), .rst_n(rst_n), .res_valid(res_valid), .res_pass(res_pass),
    .busy(busy), .clr_req(clr_req), .blink_mode(blink_mode),
    .pass_drv_n(pass_drv_n), .fail_drv_n(fail_drv_n)
  );

  task automatic chk(input string req, input logic [1:0] exp);
    n_tests++;
    if ({pass_drv_n, fail_drv_n} !== exp) begin
      n_fail++;
      $display("FAIL %s: got {pass,fail}=%b expected %b", req, {pass_drv_n, fail_drv_n}, exp);
    end
  endtask

  // one-cycle strobe; returns at the negedge after the accepting edge
  task automatic verdict(input logic pass, input logic mode);
    @(negedge clk);
    res_valid = 1'b1; res_pass = pass; blink_mode = mode;
    @(negedge clk);
    res_valid = 1'b0;
  endtask

  task automatic do_clear();
    @(negedge clk); clr_req = 1'b1;
    @(negedge clk); clr_req = 1'b0;
  endtask

  task automatic t_reset();
    rst_n = 1'b0; res_valid = 0; res_pass = 0; busy = 0; clr_req = 0; blink_mode = 0;
    repeat (3) @(negedge clk);
    chk("R1 reset", 2'b11);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1 after release", 2'b11);
  endtask

  task automatic t_pass();
    verdict(1'b1, 1'b0);
    chk("R2 pass shown", 2'b01);
    repeat (5) @(negedge clk);
    chk("R2 pass held", 2'b01);
  endtask

  task automatic t_fail_steady();
    verdict(1'b0, 1'b0);
    chk("R3 steady fail", 2'b10);
    repeat (9) @(negedge clk);
    chk("R3 steady fail held", 2'b10);
  endtask

  task automatic t_blink();
    verdict(1'b0, 1'b1);
    for (int i = 0; i < 4*HALF; i++) begin
      chk($sformatf("R4 blink cycle %0d", i), ((i / HALF) % 2 == 0) ? 2'b10 : 2'b11);
      @(negedge clk);
    end
  endtask

  task automatic t_restart();
    verdict(1'b0, 1'b1);
    repeat (HALF + 2) @(negedge clk);
    chk("R5 in high phase", 2'b11);
    verdict(1'b0, 1'b1);
    for (int i = 0; i < 2*HALF; i++) begin
      chk($sformatf("R5 restarted cycle %0d", i), (i < HALF) ? 2'b10 : 2'b11);
      @(negedge clk);
    end
  endtask

  task automatic t_busy();
    verdict(1'b1, 1'b0);
    @(negedge clk); busy = 1'b1;
    res_valid = 1'b1; res_pass = 1'b0; blink_mode = 1'b0;
    @(negedge clk); res_valid = 1'b0;
    @(negedge clk);
    chk("R6 strobe ignored while busy", 2'b01);
    busy = 1'b0;
    @(negedge clk);
    chk("R6 still pass after busy", 2'b01);
  endtask

  task automatic t_clear();
    verdict(1'b0, 1'b0);
    do_clear();
    chk("R7 clear releases", 2'b11);
    @(negedge clk);
    res_valid = 1'b1; res_pass = 1'b1; clr_req = 1'b1;
    @(negedge clk);
    res_valid = 1'b0; clr_req = 1'b0;
    chk("R7 clear beats strobe", 2'b11);
    verdict(1'b1, 1'b0);
    @(negedge clk); busy = 1'b1; clr_req = 1'b1;
    @(negedge clk); clr_req = 1'b0; busy = 1'b0;
    chk("R7 clear during busy", 2'b11);
  endtask

  task automatic t_mode_latch();
    verdict(1'b0, 1'b0);
    blink_mode = 1'b1;
    for (int i = 0; i < 2*HALF + 1; i++) begin
      chk("R8 steady fail despite mode flip", 2'b10);
      @(negedge clk);
    end
    verdict(1'b0, 1'b1);
    blink_mode = 1'b0;
    repeat (HALF) @(negedge clk);
    chk("R8 blink survives mode flip", 2'b11);
  endtask

  task automatic t_exclusive();
    // R9 across a pass-to-fail switch
    verdict(1'b1, 1'b0);
    verdict(1'b0, 1'b0);
    chk("R9 pass released on fail", 2'b10);
    verdict(1'b1, 1'b0);
    chk("R9 fail released on pass", 2'b01);
  endtask

  initial begin
    t_reset();
    t_pass();
    t_fail_steady();
    t_blink();
    t_restart();
    t_busy();
    t_clear();
    t_mode_latch();
    t_exclusive();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog: got running expected finished");
      end
    join_any
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule